// File: doc/BRIEF.md
# DMA Level-Sensed Request Sequencer

This block is the request front end of one DMA channel working in single-address mode. While the channel is enabled, it samples an active-low request line on every clock edge. It holds a low sample as a pending request. It then turns that request into one bus transfer through a bus-request/grant handshake: a request phase, one address phase and one strobe phase.

The pending request is dropped when the channel activates. From that edge until the strobe phase ends, the request line is not looked at. An optional spacing bit adds one more blind cycle after each completed transfer. A transfer counter is loaded when the enable bit goes from 0 to 1. The channel stops and flags completion when the counter runs out.

Top module: `dma_req_seq`

## Requirements
- R1: A synchronous active-high reset drives bus request, address phase, strobe and done low, and clears any pending request.
- R2: The request line is first sampled on the edge after the edge that sees the enable rise. With the line held low from before the enable rise, bus request first reads 1 after the third rising edge counted from that enable edge.
- R3: While the request line stays high, no bus request is raised.
- R4: A low level seen on a single sampling edge is held as a pending request, and it produces exactly one transfer.
- R5: Bus request stays 1 until bus grant is seen at an edge. Address phase is then 1 for exactly one cycle, and the strobe is 1 for exactly the following cycle. At most one of the three outputs is 1 at any time.
- R6: Low levels on the request line between activation and the end of the strobe cycle are ignored.
- R7: With the spacing bit 0 and the request line held low, the strobe rises every 5 cycles.
- R8: With the spacing bit 1 and the request line held low, the strobe rises every 6 cycles, because of one extra blind cycle after each strobe.
- R9: Exactly the loaded count of strobes is issued. Done then reads 1, and the request line is ignored from then on.
- R10: A loaded count of 0 sets done on the enable edge and issues no transfer.
- R11: Clearing enable during a transfer lets the current strobe occur and blocks any later request.
- R12: A new enable rise reloads the count and clears done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| chan_en | input | 1 | Channel enable; a rise loads the count |
| gap_en | input | 1 | Adds one blind cycle after each transfer |
| xfer_count | input | CNT_W | Number of transfers to run |
| dreq_n | input | 1 | Transfer request, active low, level sensed |
| bus_gnt | input | 1 | Bus grant |
| bus_req | output | 1 | Bus request |
| addr_phase | output | 1 | Address phase of the single cycle |
| xfer_stb | output | 1 | Transfer strobe, one cycle per transfer |
| done | output | 1 | Count exhausted |

## Verification
The assertions assume that reset is applied at time zero. They also assume that the enable bit does not rise again while a transfer is in flight, since a reload in the middle of a cycle has no defined result. The stimulus changes its inputs only on falling edges. It raises enable only from reset or from an idle channel. It holds grant either steadily high or low until a chosen edge, so every check sees a single clean transition per edge.

// File: rtl/dma_req_seq.sv
module dma_req_seq #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chan_en,
  input  logic             gap_en,
  input  logic [CNT_W-1:0] xfer_count,
  input  logic             dreq_n,
  input  logic             bus_gnt,
  output logic             bus_req,
  output logic             addr_phase,
  output logic             xfer_stb,
  output logic             done
);

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_ADDR, S_STB, S_GAP} st_t;

  st_t              st;
  logic             pend, run, en_d, done_q;
  logic [CNT_W-1:0] cnt;

  wire en_rise = chan_en & ~en_d;
  wire accept  = run & chan_en & ~dreq_n;
  wire last    = (cnt <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      pend   <= 1'b0;
      run    <= 1'b0;
      en_d   <= 1'b0;
      done_q <= 1'b0;
      cnt    <= '0;
    end else begin
      en_d <= chan_en;
      if (en_rise) begin
        cnt    <= xfer_count;
        run    <= (xfer_count != '0);
        done_q <= (xfer_count == '0);
      end
      case (st)
        S_IDLE: begin
          if (pend) begin
            pend <= 1'b0;
            st   <= S_REQ;
          end else if (accept) begin
            pend <= 1'b1;
          end
        end
        S_REQ:  if (bus_gnt) st <= S_ADDR;
        S_ADDR: st <= S_STB;
        S_STB: begin
          cnt <= cnt - CNT_W'(1);
          if (last) begin
            run    <= 1'b0;
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            st <= gap_en ? S_GAP : S_IDLE;
          end
        end
        S_GAP:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign bus_req    = (st == S_REQ);
  assign addr_phase = (st == S_ADDR);
  assign xfer_stb   = (st == S_STB);
  assign done       = done_q;

  assert_phase_excl_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bus_req, addr_phase, xfer_stb}));

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_gnt |=> bus_req);

  assert_addr_then_stb_R5: assert property (@(posedge clk) disable iff (rst)
    addr_phase |=> xfer_stb);

  assert_stb_after_addr_R5: assert property (@(posedge clk) disable iff (rst)
    xfer_stb |-> $past(addr_phase));

  assert_busy_blind_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_req || addr_phase) |=> !pend);

  assert_gap_blind_R8: assert property (@(posedge clk) disable iff (rst)
    $past(xfer_stb) && $past(gap_en) |-> !pend && !bus_req);

  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    done && !chan_en |=> !bus_req && !pend);

  assert_no_latch_off_R11: assert property (@(posedge clk) disable iff (rst)
    !chan_en && !pend |=> !pend);

endmodule

// File: tb/sim_dma_req_seq.sv
module sim_dma_req_seq;
  logic clk = 1'b0;
  logic rst, chan_en, gap_en, dreq_n, bus_gnt;
  logic [15:0] xfer_count;
  logic bus_req, addr_phase, xfer_stb, done;
  int n_chk = 0, n_fail = 0;
  bit wd_fired = 1'b0;

  always #10 clk = ~clk;

  dma_req_seq #(.CNT_W(16)) u0 (
    .clk(clk), .rst(rst), .chan_en(chan_en), .gap_en(gap_en),
    .xfer_count(xfer_count), .dreq_n(dreq_n), .bus_gnt(bus_gnt),
    .bus_req(bus_req), .addr_phase(addr_phase), .xfer_stb(xfer_stb), .done(done));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; chan_en = 0; gap_en = 0; dreq_n = 1; bus_gnt = 1; xfer_count = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
  endtask

  // Starts the channel at a falling edge; that edge is index 0.
  task automatic start(input int n, input logic g);
    xfer_count = 16'(n); gap_en = g; chan_en = 1;
  endtask

  task automatic t_reset_R1();
    @(negedge clk);
    rst = 1; chan_en = 1; dreq_n = 0; xfer_count = 4;
    @(negedge clk); @(negedge clk);
    chk("R1 bus_req", int'(bus_req), 0);
    chk("R1 addr_phase", int'(addr_phase), 0);
    chk("R1 xfer_stb", int'(xfer_stb), 0);
    chk("R1 done", int'(done), 0);
    do_reset();
  endtask

  task automatic t_first_sample_R2();
    do_reset();
    @(negedge clk); dreq_n = 0; start(3, 0);
    @(negedge clk); @(negedge clk);
    chk("R2 no req at index 2", int'(bus_req), 0);
    @(negedge clk);
    chk("R2 req at index 3", int'(bus_req), 1);
  endtask

  task automatic t_idle_R3();
    int seen = 0;
    do_reset();
    @(negedge clk); start(3, 0);
    for (int i = 0; i < 15; i++) begin @(negedge clk); if (bus_req) seen++; end
    chk("R3 no req with line high", seen, 0);
  endtask

  task automatic t_pulse_R4_R6();
    int strobes = 0;
    do_reset();
    @(negedge clk); start(3, 0);
    @(negedge clk); dreq_n = 0;
    @(negedge clk); dreq_n = 0;
    @(negedge clk); chk("R4 pulse gives req", int'(bus_req), 1);
    @(negedge clk); dreq_n = 1;
    @(negedge clk); chk("R4 strobe at index 5", int'(xfer_stb), 1);
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (xfer_stb) strobes++; end
    chk("R4 R6 single transfer", strobes, 0);
  endtask

  task automatic t_busy_blind_R6();
    int strobes = 0;
    do_reset();
    @(negedge clk); start(3, 0);
    @(negedge clk); dreq_n = 0;
    @(negedge clk);
    @(negedge clk); chk("R6 req raised", int'(bus_req), 1);
    @(negedge clk);
    @(negedge clk); chk("R6 strobe", int'(xfer_stb), 1); dreq_n = 1;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (xfer_stb) strobes++; end
    chk("R6 busy-window lows ignored", strobes, 0);
  endtask

  task automatic t_grant_wait_R5();
    do_reset();
    bus_gnt = 0;
    @(negedge clk); dreq_n = 0; start(3, 0);
    for (int i = 1; i <= 8; i++) @(negedge clk);
    chk("R5 req held without grant", int'(bus_req), 1);
    chk("R5 no addr without grant", int'(addr_phase), 0);
    bus_gnt = 1;
    @(negedge clk);
    chk("R5 addr phase", int'(addr_phase), 1);
    chk("R5 no strobe with addr", int'(xfer_stb), 0);
    @(negedge clk);
    chk("R5 strobe follows", int'(xfer_stb), 1);
    chk("R5 addr one cycle", int'(addr_phase), 0);
    dreq_n = 1;
  endtask

  task automatic run_spacing(input logic g, input int n, input string tag,
                             output int first, output int space, output int cnt,
                             output int done_at);
    int prev = -1;
    first = -1; space = -1; cnt = 0; done_at = -1;
    do_reset();
    @(negedge clk); dreq_n = 0; start(n, g);
    for (int i = 1; i <= 60; i++) begin
      @(negedge clk);
      if (xfer_stb) begin
        if (first < 0) first = i;
        if (prev >= 0 && space < 0) space = i - prev;
        if (prev >= 0 && (i - prev) != space) chk({tag, " uneven spacing"}, i - prev, space);
        prev = i; cnt++;
      end
      if (done && done_at < 0) done_at = i;
    end
  endtask

  task automatic t_spacing0_R7();
    int f, s, c, d;
    run_spacing(0, 4, "R7", f, s, c, d);
    chk("R7 first strobe", f, 5);
    chk("R7 spacing", s, 5);
  endtask

  task automatic t_spacing1_R8();
    int f, s, c, d;
    run_spacing(1, 4, "R8", f, s, c, d);
    chk("R8 first strobe", f, 5);
    chk("R8 spacing", s, 6);
  endtask

  task automatic t_count_R9();
    int f, s, c, d;
    run_spacing(0, 3, "R9", f, s, c, d);
    chk("R9 strobe count", c, 3);
    chk("R9 done index", d, 16);
    chk("R9 no req after done", int'(bus_req), 0);
  endtask

  task automatic t_zero_R10();
    int strobes = 0;
    do_reset();
    @(negedge clk); dreq_n = 0; start(0, 0);
    @(negedge clk); chk("R10 done at once", int'(done), 1);
    for (int i = 0; i < 15; i++) begin @(negedge clk); if (xfer_stb || bus_req) strobes++; end
    chk("R10 no transfer", strobes, 0);
  endtask

  task automatic t_disable_R11();
    int strobes = 0;
    do_reset();
    @(negedge clk); dreq_n = 0; start(5, 0);
    @(negedge clk); @(negedge clk); @(negedge clk);
    chan_en = 0;
    @(negedge clk);
    @(negedge clk); chk("R11 current strobe finishes", int'(xfer_stb), 1);
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (bus_req) strobes++; end
    chk("R11 no further request", strobes, 0);
    chk("R11 not done", int'(done), 0);
  endtask

  task automatic t_reload_R12();
    int strobes = 0;
    do_reset();
    @(negedge clk); dreq_n = 0; start(1, 0);
    for (int i = 0; i < 10; i++) @(negedge clk);
    chk("R12 first run done", int'(done), 1);
    chan_en = 0;
    @(negedge clk); start(2, 0);
    @(negedge clk); chk("R12 done cleared", int'(done), 0);
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (xfer_stb) strobes++; end
    chk("R12 reloaded count", strobes, 2);
    chk("R12 done again", int'(done), 1);
  endtask

  initial begin
    #(20 * 100000);
    wd_fired = 1'b1;
  end

  initial begin
    rst = 1; chan_en = 0; gap_en = 0; dreq_n = 1; bus_gnt = 1; xfer_count = 0;
    fork
      begin
        t_reset_R1();
        t_first_sample_R2();
        t_idle_R3();
        t_pulse_R4_R6();
        t_busy_blind_R6();
        t_grant_wait_R5();
        t_spacing0_R7();
        t_spacing1_R8();
        t_count_R9();
        t_zero_R10();
        t_disable_R11();
        t_reload_R12();
      end
      wait (wd_fired);
    join_any
    disable fork;
    if (wd_fired) chk("watchdog", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule